// File: doc/BRIEF.md
# Two-Way Lockable Write-Back Data Cache

This block is a 1 KB two-way set-associative data cache. It sits between a processor load/store port and a memory port that moves one 32-bit word per handshake. Lines are 16 bytes and addresses are physical. Each line is invalid, clean or modified. Stores stay in the cache until the line is evicted or explicitly cleaned. The victim within a set is the least-recently-used way.

Besides loads and stores, the same request port takes maintenance commands: prefetch a line (two codes), drop a line, write back a line, drop every line, and set or clear a per-line lock. A global enable sends all accesses straight to memory. A global lock freezes allocation without affecting hits. One command is accepted at a time. Each accepted command ends with a single-cycle response pulse.

Top module: `dcache_2way`

## Requirements
- R1: Address bits [3:0] select the byte in a line, [8:4] the set, and the bits above form the tag, which is compared against both ways. A load miss reads the line as four single-word memory reads at ascending word addresses and returns the addressed word.
- R2: A load or store that hits makes no memory access, and a load returns the most recent value stored to that word.
- R3: A store hit marks the line modified without writing memory. A line is never modified while invalid.
- R4: On a miss, an invalid way is filled first (way 0 before way 1); otherwise the least-recently-used way is replaced. Every hit or fill makes that way most recent.
- R5: Replacing a modified line first writes its four words to memory, then reads the four words of the new line. Only modified lines are written back.
- R6: A store miss allocates the line (four reads), then merges the stored word, and the other words of the line keep their memory values.
- R7: Op codes 2 (prefetch) and 3 (prefetch-for-store) load an absent line with four reads and make no memory access when the line is present.
- R8: Op code 4 drops the addressed line without writing it back and clears its lock; a later load of it misses.
- R9: Op code 5 writes a modified line's four words to memory and leaves it valid and clean; on a clean or absent line it makes no memory access.
- R10: Op code 6 invalidates every line and clears every lock, with no write-back.
- R11: Op code 7 sets the hit line's lock to bit 0 of the write data. A locked line is never replaced. When both ways are locked, a load or store miss makes one direct single-word memory access without allocating, and a prefetch does nothing.
- R12: With global lock high, misses make one direct single-word memory access and never allocate, while hits behave normally.
- R13: With enable low, loads (code 0) and stores (code 1) make one direct single-word memory access. Every other command except code 6 has no effect, and the tag, state, lock and LRU contents stay unchanged.
- R14: req_ready_o is high only while idle and never while a response or memory request is active. resp_valid_o pulses for exactly one cycle per accepted command. A memory request holds its address until acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Cache enable; low sends accesses to memory |
| global_lock_i | input | 1 | Forbid allocation on misses |
| req_valid_i | input | 1 | Command request |
| req_ready_o | output | 1 | Idle, command accepted this cycle |
| req_op_i | input | 3 | Command code |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Store data, or lock value in bit 0 |
| resp_valid_o | output | 1 | Command complete pulse |
| resp_rdata_o | output | DATA_W | Load data |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Memory completes the word this cycle |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
A wrong tag or state bit shows at the ports on the next access to that set. A stale or missing line changes the count of memory reads from zero to four, or the reverse. A lost dirty bit shows up as missing write-back words when the line is replaced or cleaned, and as an old value read back from memory. A wrong LRU or lock bit evicts the wrong way, and this appears one access later as an unexpected refill. The bench therefore counts memory reads and writes per command and compares read data against values it computes itself. This exposes each fault within two or three commands of the corruption.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int unsigned WAYS = 2;

  typedef enum logic [2:0] {
    OP_LOAD     = 3'd0,
    OP_STORE    = 3'd1,
    OP_TOUCH    = 3'd2,
    OP_TOUCH_ST = 3'd3,
    OP_INV_LINE = 3'd4,
    OP_CLEAN    = 3'd5,
    OP_INV_ALL  = 3'd6,
    OP_LOCK     = 3'd7
  } dc_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_FILL, S_BYP, S_DONE
  } dc_state_e;
endpackage

// File: rtl/dc_tag_match.sv
module dc_tag_match #(
  parameter int unsigned TAG_W = 23,
  parameter int unsigned WAYS  = 2
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            hit_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end
endmodule

// File: rtl/dc_victim_sel.sv
module dc_victim_sel (
  input  logic [1:0] valid_i,
  input  logic [1:0] lock_i,
  input  logic       lru_i,
  input  logic       glock_i,
  output logic       victim_o,
  output logic       alloc_o
);
  logic [1:0] free;
  assign free    = ~lock_i;
  assign alloc_o = (|free) && !glock_i;

  always_comb begin
    if (free == 2'b11) begin
      if (!valid_i[0])      victim_o = 1'b0;
      else if (!valid_i[1]) victim_o = 1'b1;
      else                  victim_o = lru_i;
    end else begin
      victim_o = free[1];
    end
  end
endmodule

// File: rtl/dc_line_ram.sv
module dc_line_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcache_2way.sv
module dcache_2way
  import dc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SETS       = 32,
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              global_lock_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned BYTES_W = $clog2(DATA_W / 8);
  localparam int unsigned WOFF_W  = $clog2(LINE_WORDS);
  localparam int unsigned OFF_W   = BYTES_W + WOFF_W;
  localparam int unsigned IDX_W   = $clog2(SETS);
  localparam int unsigned TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int unsigned RAM_AW  = IDX_W + 1 + WOFF_W;
  localparam logic [WOFF_W-1:0] LAST = WOFF_W'(LINE_WORDS - 1);

  dc_state_e state_q;
  dc_op_e    op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              way_q;
  logic [WOFF_W-1:0] cnt_q;

  logic [SETS-1:0][WAYS-1:0] valid_q, dirty_q, lock_q;
  logic [SETS-1:0]           lru_q;
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WOFF_W-1:0] woff;
  assign idx  = addr_q[OFF_W +: IDX_W];
  assign tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign woff = addr_q[BYTES_W +: WOFF_W];

  logic [WAYS-1:0] hit;
  logic any_hit, hit_way, victim, alloc_ok;
  assign any_hit = |hit;
  assign hit_way = hit[1];

  dc_tag_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
    .tags_i(tag_q[idx]), .valid_i(valid_q[idx]), .tag_i(tag), .hit_o(hit)
  );

  dc_victim_sel u_victim (
    .valid_i(valid_q[idx]), .lock_i(lock_q[idx]), .lru_i(lru_q[idx]),
    .glock_i(global_lock_i), .victim_o(victim), .alloc_o(alloc_ok)
  );

  logic is_access, is_fetch, fill_last;
  assign is_access = (op_q == OP_LOAD) || (op_q == OP_STORE);
  assign is_fetch  = is_access || (op_q == OP_TOUCH) || (op_q == OP_TOUCH_ST);
  assign fill_last = (state_q == S_FILL) && mem_ack_i && (cnt_q == LAST);

  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = {idx, hit_way, woff};
    ram_wdata = wdata_q;
    if (state_q == S_LOOK && op_q == OP_STORE && enable_i && any_hit) begin
      ram_we = 1'b1;
    end else if (state_q == S_FILL && mem_ack_i) begin
      ram_we    = 1'b1;
      ram_waddr = {idx, way_q, cnt_q};
      // merge the pending store into its word of the incoming line
      ram_wdata = (op_q == OP_STORE && cnt_q == woff) ? wdata_q : mem_rdata_i;
    end
  end

  assign ram_raddr = (state_q == S_WB) ? {idx, way_q, cnt_q} : {idx, hit_way, woff};

  dc_line_ram #(.DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
    .clk_i(clk_i), .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
    .raddr_i(ram_raddr), .rdata_o(ram_rdata)
  );

  always_comb begin
    case (state_q)
      S_WB:    mem_addr_o = {tag_q[idx][way_q], idx, cnt_q, {BYTES_W{1'b0}}};
      S_FILL:  mem_addr_o = {tag, idx, cnt_q, {BYTES_W{1'b0}}};
      default: mem_addr_o = {addr_q[ADDR_W-1:BYTES_W], {BYTES_W{1'b0}}};
    endcase
  end

  assign mem_req_o    = (state_q == S_WB) || (state_q == S_FILL) || (state_q == S_BYP);
  assign mem_we_o     = (state_q == S_WB) || (state_q == S_BYP && op_q == OP_STORE);
  assign mem_wdata_o  = (state_q == S_WB) ? ram_rdata : wdata_q;
  assign req_ready_o  = (state_q == S_IDLE);
  assign resp_valid_o = (state_q == S_DONE);
  assign resp_rdata_o = rdata_q;

  always_ff @(posedge clk_i) begin
    if (fill_last) tag_q[idx][way_q] <= tag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      way_q   <= 1'b0;
      cnt_q   <= '0;
      valid_q <= '0;
      dirty_q <= '0;
      lock_q  <= '0;
      lru_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          op_q    <= dc_op_e'(req_op_i);
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          state_q <= S_LOOK;
        end
        S_LOOK: begin
          cnt_q   <= '0;
          state_q <= S_DONE;
          if (op_q == OP_INV_ALL) begin
            valid_q <= '0;
            dirty_q <= '0;
            lock_q  <= '0;
          end else if (!enable_i) begin
            if (is_access) state_q <= S_BYP;
          end else if (any_hit) begin
            case (op_q)
              OP_LOAD: begin
                rdata_q    <= ram_rdata;
                lru_q[idx] <= ~hit_way;
              end
              OP_STORE: begin
                dirty_q[idx][hit_way] <= 1'b1;
                lru_q[idx]            <= ~hit_way;
              end
              OP_TOUCH, OP_TOUCH_ST: lru_q[idx] <= ~hit_way;
              OP_INV_LINE: begin
                valid_q[idx][hit_way] <= 1'b0;
                dirty_q[idx][hit_way] <= 1'b0;
                lock_q[idx][hit_way]  <= 1'b0;
              end
              OP_CLEAN: if (dirty_q[idx][hit_way]) begin
                way_q   <= hit_way;
                state_q <= S_WB;
              end
              OP_LOCK: lock_q[idx][hit_way] <= wdata_q[0];
              default: ;
            endcase
          end else if (is_fetch) begin
            if (alloc_ok) begin
              way_q   <= victim;
              state_q <= (valid_q[idx][victim] && dirty_q[idx][victim]) ? S_WB : S_FILL;
            end else if (is_access) begin
              state_q <= S_BYP;
            end
          end
        end
        S_WB: if (mem_ack_i) begin
          cnt_q <= cnt_q + WOFF_W'(1);
          if (cnt_q == LAST) begin
            if (op_q == OP_CLEAN) begin
              dirty_q[idx][way_q] <= 1'b0;
              state_q             <= S_DONE;
            end else begin
              state_q <= S_FILL;
            end
          end
        end
        S_FILL: if (mem_ack_i) begin
          cnt_q <= cnt_q + WOFF_W'(1);
          if (cnt_q == woff) rdata_q <= mem_rdata_i;
          if (cnt_q == LAST) begin
            valid_q[idx][way_q] <= 1'b1;
            dirty_q[idx][way_q] <= (op_q == OP_STORE);
            lru_q[idx]          <= ~way_q;
            state_q             <= S_DONE;
          end
        end
        S_BYP: if (mem_ack_i) begin
          rdata_q <= mem_rdata_i;
          state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dc_chk.sv
module dc_chk
  import dc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SETS   = 32,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      enable_i,
  input logic                      req_ready_o,
  input logic                      resp_valid_o,
  input logic                      mem_req_o,
  input logic                      mem_we_o,
  input logic                      mem_ack_i,
  input logic [ADDR_W-1:0]         mem_addr_o,
  input logic [SETS-1:0][WAYS-1:0] valid_q,
  input logic [SETS-1:0][WAYS-1:0] dirty_q,
  input logic [SETS-1:0][WAYS-1:0] lock_q,
  input logic [SETS-1:0]           lru_q,
  input dc_state_e                 state_q,
  input dc_op_e                    op_q,
  input logic [IDX_W-1:0]          idx,
  input logic                      way_q
);
  // R14
  resp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);

  // R14
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !(resp_valid_o || mem_req_o));

  // R14
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R3
  dirty_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dirty_q & ~valid_q) == '0);

  // R11
  lock_victim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FILL) |-> !lock_q[idx][way_q]);

  // R5
  wb_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WB && mem_we_o) |-> dirty_q[idx][way_q]);

  // R13
  disabled_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LOOK && !enable_i && op_q != OP_INV_ALL) |=>
      ($stable(valid_q) && $stable(dirty_q) && $stable(lock_q) && $stable(lru_q)));
endmodule

bind dcache_2way dc_chk #(.ADDR_W(ADDR_W), .SETS(SETS)) u_chk (.*);

// File: tb/tb_dcache_2way.sv
module tb_dcache_2way;
  localparam logic [2:0] LD = 3'd0, ST = 3'd1, TCH = 3'd2, TCHS = 3'd3,
                         INV = 3'd4, CLN = 3'd5, INVA = 3'd6, LCK = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b1, glock = 1'b0, req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, resp_valid, mem_req, mem_we, mem_ack;
  logic [31:0] resp_rdata, mem_addr, mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  dcache_2way dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .global_lock_i(glock),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .resp_valid_o(resp_valid),
    .resp_rdata_o(resp_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata)
  );

  logic [31:0] mem [4096];
  int rd_cnt = 0, wr_cnt = 0;
  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[13:2]];
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  int vec = 0, fails = 0;
  bit done = 1'b0;

  function automatic logic [31:0] initv(logic [31:0] a);
    return {a[15:2], a[15:2], 4'h0} ^ 32'hA5C3_0F1E;
  endfunction

  function automatic logic [31:0] ad(int t, int s, int w);
    return 32'(t * 512 + s * 16 + w * 4);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output int nr, output int nw);
    int r0, w0;
    @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    rd = resp_rdata; nr = rd_cnt - r0; nw = wr_cnt - w0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R14 watchdog: act=hung exp=complete");
    summary();
  end

  initial begin
    logic [31:0] d;
    int nr, nw;
    for (int i = 0; i < 4096; i++) mem[i] = initv(32'(i * 4));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14", "reset ready", 32'(req_ready), 32'd1);
    chk("R14", "reset resp", 32'(resp_valid), 32'd0);
    chk("R14", "reset memreq", 32'(mem_req), 32'd0);

    // R1 load miss then R2 hit
    run(LD, ad(0,1,2), 0, d, nr, nw);
    chk("R1", "miss data", d, initv(ad(0,1,2)));
    chk("R1", "miss reads", nr, 4);
    chk("R1", "miss writes", nw, 0);
    run(LD, ad(0,1,3), 0, d, nr, nw);
    chk("R2", "hit reads", nr, 0);
    chk("R2", "hit data", d, initv(ad(0,1,3)));

    // R3 store hit stays in cache
    run(ST, ad(0,1,3), 32'h1111_2222, d, nr, nw);
    chk("R3", "store hit traffic", nr + nw, 0);
    chk("R3", "memory untouched", mem[ad(0,1,3) >> 2], initv(ad(0,1,3)));
    run(LD, ad(0,1,3), 0, d, nr, nw);
    chk("R2", "load after store", d, 32'h1111_2222);

    // R4 LRU in set 2
    run(LD, ad(0,2,0), 0, d, nr, nw);
    run(LD, ad(1,2,0), 0, d, nr, nw);
    chk("R4", "invalid way used", nr, 4);
    run(LD, ad(0,2,0), 0, d, nr, nw);
    chk("R4", "t0 hit", nr, 0);
    run(LD, ad(2,2,0), 0, d, nr, nw);
    run(LD, ad(0,2,0), 0, d, nr, nw);
    chk("R4", "mru kept", nr, 0);
    run(LD, ad(1,2,0), 0, d, nr, nw);
    chk("R4", "lru evicted", nr, 4);

    // R5 dirty eviction in set 1
    run(LD, ad(1,1,0), 0, d, nr, nw);
    chk("R5", "second way fill writes", nw, 0);
    run(LD, ad(2,1,0), 0, d, nr, nw);
    chk("R5", "evict writes", nw, 4);
    chk("R5", "evict reads", nr, 4);
    chk("R5", "written back", mem[ad(0,1,3) >> 2], 32'h1111_2222);

    // R6 store miss allocate
    run(ST, ad(3,5,1), 32'hCAFE_0001, d, nr, nw);
    chk("R6", "alloc reads", nr, 4);
    chk("R6", "alloc writes", nw, 0);
    run(LD, ad(3,5,1), 0, d, nr, nw);
    chk("R6", "merged word", d, 32'hCAFE_0001);
    chk("R6", "merged hit", nr, 0);
    run(LD, ad(3,5,2), 0, d, nr, nw);
    chk("R6", "other word", d, initv(ad(3,5,2)));

    // R7 prefetch codes
    run(TCH, ad(4,6,0), 0, d, nr, nw);
    chk("R7", "touch reads", nr, 4);
    run(LD, ad(4,6,3), 0, d, nr, nw);
    chk("R7", "touched hit", nr, 0);
    run(TCHS, ad(5,6,0), 0, d, nr, nw);
    chk("R7", "touch_st reads", nr, 4);
    run(TCHS, ad(5,6,2), 0, d, nr, nw);
    chk("R7", "touch present", nr + nw, 0);

    // R9 clean
    run(ST, ad(4,6,0), 32'h0BAD_F00D, d, nr, nw);
    run(CLN, ad(4,6,0), 0, d, nr, nw);
    chk("R9", "clean writes", nw, 4);
    chk("R9", "clean memory", mem[ad(4,6,0) >> 2], 32'h0BAD_F00D);
    run(CLN, ad(4,6,0), 0, d, nr, nw);
    chk("R9", "reclean traffic", nr + nw, 0);
    run(LD, ad(4,6,0), 0, d, nr, nw);
    chk("R9", "still valid", nr, 0);
    run(CLN, ad(9,6,0), 0, d, nr, nw);
    chk("R9", "clean absent", nr + nw, 0);

    // R8 invalidate line
    run(ST, ad(5,6,1), 32'h5555_AAAA, d, nr, nw);
    run(INV, ad(5,6,1), 0, d, nr, nw);
    chk("R8", "inv traffic", nr + nw, 0);
    run(LD, ad(5,6,1), 0, d, nr, nw);
    chk("R8", "inv miss", nr, 4);
    chk("R8", "data dropped", d, initv(ad(5,6,1)));

    // R11 per-line lock in set 7
    run(LD, ad(0,7,0), 0, d, nr, nw);
    run(LCK, ad(0,7,0), 1, d, nr, nw);
    run(LD, ad(1,7,0), 0, d, nr, nw);
    run(LD, ad(0,7,0), 0, d, nr, nw);
    run(LD, ad(2,7,0), 0, d, nr, nw);
    run(LD, ad(3,7,0), 0, d, nr, nw);
    run(LD, ad(0,7,0), 0, d, nr, nw);
    chk("R11", "locked survives", nr, 0);
    run(LCK, ad(3,7,0), 1, d, nr, nw);
    run(LD, ad(4,7,0), 0, d, nr, nw);
    chk("R11", "bypass reads", nr, 1);
    chk("R11", "bypass data", d, initv(ad(4,7,0)));
    run(LD, ad(4,7,0), 0, d, nr, nw);
    chk("R11", "not allocated", nr, 1);
    run(TCH, ad(4,7,0), 0, d, nr, nw);
    chk("R11", "touch locked set", nr + nw, 0);
    run(LCK, ad(0,7,0), 0, d, nr, nw);
    run(LCK, ad(3,7,0), 0, d, nr, nw);
    run(LD, ad(4,7,0), 0, d, nr, nw);
    chk("R11", "unlocked alloc", nr, 4);

    // R8 invalidate clears lock (set 8)
    run(LD, ad(0,8,0), 0, d, nr, nw);
    run(LCK, ad(0,8,0), 1, d, nr, nw);
    run(INV, ad(0,8,0), 0, d, nr, nw);
    run(LD, ad(1,8,0), 0, d, nr, nw);
    run(LD, ad(2,8,0), 0, d, nr, nw);
    run(LD, ad(3,8,0), 0, d, nr, nw);
    run(LD, ad(1,8,0), 0, d, nr, nw);
    chk("R8", "lock cleared", nr, 4);

    // R12 global lock
    glock = 1'b1;
    run(LD, ad(9,9,0), 0, d, nr, nw);
    chk("R12", "glock bypass", nr, 1);
    run(LD, ad(9,9,0), 0, d, nr, nw);
    chk("R12", "glock no alloc", nr, 1);
    run(LD, ad(3,5,1), 0, d, nr, nw);
    chk("R12", "glock hit", nr, 0);
    chk("R12", "glock hit data", d, 32'hCAFE_0001);
    glock = 1'b0;

    // R13 disabled
    enable = 1'b0;
    run(LD, ad(3,5,1), 0, d, nr, nw);
    chk("R13", "disabled load data", d, initv(ad(3,5,1)));
    chk("R13", "disabled load reads", nr, 1);
    run(ST, ad(3,5,2), 32'h7777_0002, d, nr, nw);
    chk("R13", "disabled store writes", nw, 1);
    chk("R13", "disabled store mem", mem[ad(3,5,2) >> 2], 32'h7777_0002);
    run(TCH, ad(7,5,0), 0, d, nr, nw);
    chk("R13", "disabled touch", nr + nw, 0);
    enable = 1'b1;
    run(LD, ad(3,5,2), 0, d, nr, nw);
    chk("R13", "array unchanged", d, initv(ad(3,5,2)));
    chk("R13", "still hit", nr, 0);

    // R10 invalidate all
    run(INVA, 0, 0, d, nr, nw);
    chk("R10", "inv_all traffic", nr + nw, 0);
    run(LD, ad(3,5,1), 0, d, nr, nw);
    chk("R10", "dirty dropped", d, initv(ad(3,5,1)));
    chk("R10", "miss after", nr, 4);
    run(LD, ad(3,5,2), 0, d, nr, nw);
    chk("R10", "memory value", d, 32'h7777_0002);
    run(INVA, 0, 0, d, nr, nw);

    // sweep: every set, four tags through two ways (R2 R4 R5 R6)
    for (int s = 0; s < 32; s++)
      for (int t = 0; t < 4; t++)
        run(ST, ad(t,s,t), {16'(s), 16'(t)} ^ 32'h3C3C_0000, d, nr, nw);
    for (int s = 0; s < 32; s++)
      for (int t = 0; t < 4; t++) begin
        run(LD, ad(t,s,t), 0, d, nr, nw);
        chk("R2", "sweep data", d, {16'(s), 16'(t)} ^ 32'h3C3C_0000);
        chk("R5", "sweep writes", nw, (t < 2) ? 4 : 0);
        chk("R4", "sweep reads", nr, 4);
      end

    summary();
  end
endmodule